// File: doc/BRIEF.md
# Strap Latch and Clock Configuration Merge

This block sits between the board-level configuration straps of a system clock generator and its output stage. When the active-low asynchronous power-on reset is released, the first rising clock edge copies the strap levels into a holding register. The strap levels are a 3-bit frequency code, an SDRAM source select and a desktop/mobile select. After that edge the strap inputs are never looked at again, because the shared pins are then driving clocks.

The captured straps are merged with six serial configuration bytes. The result is the frequency code that the synthesizer uses, the SDRAM-follows-CPU flag, the desktop/mobile flag, the spread-spectrum controls, a tristate-all control and one enable bit for each clock output. A software frequency code can replace the hardware one. The two SDRAM outputs that share pins with the stop inputs are only enabled in desktop mode. Frequency synthesis is not part of this block.

Top module: `clk_strap_cfg`

## Requirements
- R1: The strap inputs are sampled on the first rising clock edge after `rst_ni` goes high, and only on that edge. Later changes on the strap inputs have no effect on any output.
- R2: While reset is asserted, and until the capture edge, the outputs take these values: `freq_code_o`=000, `sdram_cpu_o`=1, `desktop_o`=1, `ss_en_o`, `ss_wide_o`, `ss_down_o` and `tristate_o` all 0, and every enable output 1.
- R3: After capture, when bit 3 of byte 0 is 0, `freq_code_o` equals the captured frequency strap.
- R4: After capture, when bit 3 of byte 0 is 1, `freq_code_o` equals bits 6:4 of byte 0.
- R5: After capture, `sdram_cpu_o` equals the captured SDRAM-select strap (1 means follow CPU, 0 means follow AGP), and `desktop_o` equals the captured mode strap (1 is desktop, 0 is mobile).
- R6: After capture, byte 0 bit 1 drives `ss_en_o`, bit 7 drives `ss_wide_o` (0 is 0.25 %, 1 is 0.6 %), and bit 2 drives `ss_down_o` (0 is center spread, 1 is down spread).
- R7: After capture, `tristate_o` equals byte 0 bit 0.
- R8: After capture, the enables map as follows, with 1 meaning enabled: `en_cpu_o[i]`=byte1[i] for i=0..3; `en_pci_o[i]`=byte2[i] for i=0..4; `en_agp_o[0]`=byte2[5]; `en_pci_free_o`=byte2[6]; `en_sdram_o[i]`=byte3[i] for i=0..7; `en_sdram_o[8+i]`=byte4[i] for i=0..3 (gated by R9); `en_agp_o[1]`=byte5[4]; `en_ref_o[i]`=byte5[i] for i=0..1.
- R9: In mobile mode `en_sdram_o[11:10]` are 0 whatever byte 4 bits 3:2 hold. In desktop mode they follow those bits.
- R10: Changing the reserved bits has no effect on any output. The reserved bits are byte1[7:4], byte2[7], byte4[7:4] and byte5 bits 7:5 and 3:2.
- R11: Asserting reset again restores the R2 state, and the next release captures the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| fs_strap_i | input | 3 | Frequency-select strap levels |
| sdsel_strap_i | input | 1 | SDRAM source strap level |
| mode_strap_i | input | 1 | Desktop/mobile strap level |
| cfg_b0_i | input | 8 | Configuration byte 0: function and frequency |
| cfg_b1_i | input | 8 | Configuration byte 1: CPU clock enables |
| cfg_b2_i | input | 8 | Configuration byte 2: PCI/AGP0 enables |
| cfg_b3_i | input | 8 | Configuration byte 3: SDRAM 0..7 enables |
| cfg_b4_i | input | 8 | Configuration byte 4: SDRAM 8..11 enables |
| cfg_b5_i | input | 8 | Configuration byte 5: REF/AGP1 enables |
| freq_code_o | output | 3 | Effective frequency code |
| sdram_cpu_o | output | 1 | 1: SDRAM clocks follow CPU frequency |
| desktop_o | output | 1 | 1: desktop mode, 0: mobile mode |
| ss_en_o | output | 1 | Spread spectrum enable |
| ss_wide_o | output | 1 | Spread amount: 1 is 0.6 %, 0 is 0.25 % |
| ss_down_o | output | 1 | Spread type: 1 is down, 0 is center |
| tristate_o | output | 1 | Float all clock outputs |
| en_cpu_o | output | 4 | CPU clock enables |
| en_pci_o | output | 5 | Stoppable PCI clock enables |
| en_pci_free_o | output | 1 | Free-running PCI clock enable |
| en_agp_o | output | 2 | AGP clock enables |
| en_sdram_o | output | 12 | SDRAM clock enables |
| en_ref_o | output | 2 | Reference clock enables |

## Verification
The hardest case to reach from the ports is a strap change that arrives after the capture edge. That change must leave every output untouched, even though the strap pins stay connected. The bench captures one strap set, drives the opposite levels onto every strap pin, and checks that the frequency code, SDRAM source and mode still reflect the first set. It then applies reset a second time with different straps, in mobile mode, to show that a fresh capture takes place. With byte 4 all ones, it also shows that the two shared SDRAM enables stay low.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int FS_W     = 3;
  localparam int N_CPU    = 4;
  localparam int N_PCI    = 5;
  localparam int N_AGP    = 2;
  localparam int N_SDR    = 12;
  localparam int N_REF    = 2;
  localparam int SDR_LO_W = 8;            // SDRAM enables held in byte 3
  localparam int SDR_HI_W = N_SDR - SDR_LO_W;
  localparam int SDR_SHR  = 10;           // first SDRAM output shared with a stop input

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            sd_cpu;
    logic            desktop;
  } strap_t;

  typedef struct packed {
    logic en;
    logic wide;
    logic down;
  } spread_t;

  localparam strap_t STRAP_DFLT = '{fs: '0, sd_cpu: 1'b1, desktop: 1'b1};
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import clk_cfg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  strap_t pins_i,
  output strap_t strap_o,
  output logic   valid_o
);
  strap_t strap_q;
  logic   valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= STRAP_DFLT;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      strap_q <= pins_i;
      valid_q <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign valid_o = valid_q;

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> $stable(strap_q) && valid_q); // R1
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import clk_cfg_pkg::*;
(
  input  strap_t          strap_i,
  input  logic            valid_i,
  input  logic [7:0]      b0_i,
  output logic [FS_W-1:0] fs_o,
  output logic            sd_cpu_o,
  output logic            desktop_o,
  output spread_t         ss_o,
  output logic            tri_o
);
  logic            sw_sel;
  logic [FS_W-1:0] sw_fs;

  assign sw_sel = b0_i[3];
  assign sw_fs  = b0_i[6:4];

  always_comb begin
    fs_o      = strap_i.fs;
    sd_cpu_o  = strap_i.sd_cpu;
    desktop_o = strap_i.desktop;
    ss_o      = '0;
    tri_o     = 1'b0;
    if (valid_i) begin
      if (sw_sel) fs_o = sw_fs;
      ss_o.en   = b0_i[1];
      ss_o.wide = b0_i[7];
      ss_o.down = b0_i[2];
      tri_o     = b0_i[0];
    end
  end
endmodule

// File: rtl/clk_en_map.sv
module clk_en_map
  import clk_cfg_pkg::*;
(
  input  logic                valid_i,
  input  logic                desktop_i,
  input  logic [N_CPU-1:0]    cpu_b_i,
  input  logic [6:0]          pci_b_i,
  input  logic [SDR_LO_W-1:0] sdr_lo_b_i,
  input  logic [SDR_HI_W-1:0] sdr_hi_b_i,
  input  logic                agp1_b_i,
  input  logic [N_REF-1:0]    ref_b_i,
  output logic [N_CPU-1:0]    en_cpu_o,
  output logic [N_PCI-1:0]    en_pci_o,
  output logic                en_pci_free_o,
  output logic [N_AGP-1:0]    en_agp_o,
  output logic [N_SDR-1:0]    en_sdr_o,
  output logic [N_REF-1:0]    en_ref_o
);
  logic [N_SDR-1:0] sdr_raw;

  for (genvar i = 0; i < N_SDR; i++) begin : g_sdr
    if (i < SDR_LO_W) begin : g_lo
      assign sdr_raw[i] = sdr_lo_b_i[i];
    end else if (i >= SDR_SHR) begin : g_shared
      assign sdr_raw[i] = sdr_hi_b_i[i-SDR_LO_W] & desktop_i;
    end else begin : g_hi
      assign sdr_raw[i] = sdr_hi_b_i[i-SDR_LO_W];
    end
  end

  // before capture every enable reads 1
  assign en_cpu_o      = valid_i ? cpu_b_i                    : '1;
  assign en_pci_o      = valid_i ? pci_b_i[N_PCI-1:0]         : '1;
  assign en_pci_free_o = valid_i ? pci_b_i[6]                 : 1'b1;
  assign en_agp_o      = valid_i ? {agp1_b_i, pci_b_i[5]}     : '1;
  assign en_sdr_o      = valid_i ? sdr_raw                    : '1;
  assign en_ref_o      = valid_i ? ref_b_i                    : '1;
endmodule

// File: rtl/clk_strap_cfg.sv
module clk_strap_cfg
  import clk_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       fs_strap_i,
  input  logic             sdsel_strap_i,
  input  logic             mode_strap_i,
  input  logic [7:0]       cfg_b0_i,
  input  logic [7:0]       cfg_b1_i,
  input  logic [7:0]       cfg_b2_i,
  input  logic [7:0]       cfg_b3_i,
  input  logic [7:0]       cfg_b4_i,
  input  logic [7:0]       cfg_b5_i,
  output logic [2:0]       freq_code_o,
  output logic             sdram_cpu_o,
  output logic             desktop_o,
  output logic             ss_en_o,
  output logic             ss_wide_o,
  output logic             ss_down_o,
  output logic             tristate_o,
  output logic [3:0]       en_cpu_o,
  output logic [4:0]       en_pci_o,
  output logic             en_pci_free_o,
  output logic [1:0]       en_agp_o,
  output logic [11:0]      en_sdram_o,
  output logic [1:0]       en_ref_o
);
  strap_t  pins, strap;
  logic    cap_valid;
  spread_t ss;
  logic    unused_rsvd;

  assign pins = '{fs: fs_strap_i, sd_cpu: sdsel_strap_i, desktop: mode_strap_i};
  assign unused_rsvd = ^{cfg_b1_i[7:4], cfg_b2_i[7], cfg_b4_i[7:4],
                         cfg_b5_i[7:5], cfg_b5_i[3:2]};

  strap_latch i_strap_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (pins),
    .strap_o (strap),
    .valid_o (cap_valid)
  );

  cfg_decode i_cfg_decode (
    .strap_i   (strap),
    .valid_i   (cap_valid),
    .b0_i      (cfg_b0_i),
    .fs_o      (freq_code_o),
    .sd_cpu_o  (sdram_cpu_o),
    .desktop_o (desktop_o),
    .ss_o      (ss),
    .tri_o     (tristate_o)
  );

  assign ss_en_o   = ss.en;
  assign ss_wide_o = ss.wide;
  assign ss_down_o = ss.down;

  clk_en_map i_clk_en_map (
    .valid_i       (cap_valid),
    .desktop_i     (strap.desktop),
    .cpu_b_i       (cfg_b1_i[N_CPU-1:0]),
    .pci_b_i       (cfg_b2_i[6:0]),
    .sdr_lo_b_i    (cfg_b3_i),
    .sdr_hi_b_i    (cfg_b4_i[SDR_HI_W-1:0]),
    .agp1_b_i      (cfg_b5_i[4]),
    .ref_b_i       (cfg_b5_i[N_REF-1:0]),
    .en_cpu_o      (en_cpu_o),
    .en_pci_o      (en_pci_o),
    .en_pci_free_o (en_pci_free_o),
    .en_agp_o      (en_agp_o),
    .en_sdr_o      (en_sdram_o),
    .en_ref_o      (en_ref_o)
  );

  AST_PRE_CAP_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_valid |-> (&{en_cpu_o, en_pci_o, en_pci_free_o, en_agp_o, en_sdram_o, en_ref_o}) && !tristate_o); // R2
  AST_SW_FREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid && cfg_b0_i[3] |-> freq_code_o == cfg_b0_i[6:4]); // R4
  AST_HW_FREQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid && !cfg_b0_i[3] && $past(cap_valid) && !$past(cfg_b0_i[3]) |-> $stable(freq_code_o)); // R3
  AST_MOBILE_SHARED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid && !desktop_o |-> en_sdram_o[11:10] == 2'b00); // R9
endmodule

// File: tb/test_clk_strap_cfg.sv
module test_clk_strap_cfg;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] fs_s = 3'b000;
  logic sd_s = 1'b0, md_s = 1'b0;
  logic [7:0] b0 = 8'h00, b1 = 8'hFF, b2 = 8'hFF, b3 = 8'hFF, b4 = 8'hFF, b5 = 8'hFF;
  logic [2:0] freq;
  logic sd_cpu, desk, ss_en, ss_wide, ss_down, tri_st;
  logic [3:0] e_cpu;
  logic [4:0] e_pci;
  logic e_pcif;
  logic [1:0] e_agp;
  logic [11:0] e_sdr;
  logic [1:0] e_ref;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  clk_strap_cfg i_clk_strap_cfg (
    .clk_i(clk), .rst_ni(rst_ni), .fs_strap_i(fs_s), .sdsel_strap_i(sd_s),
    .mode_strap_i(md_s), .cfg_b0_i(b0), .cfg_b1_i(b1), .cfg_b2_i(b2),
    .cfg_b3_i(b3), .cfg_b4_i(b4), .cfg_b5_i(b5), .freq_code_o(freq),
    .sdram_cpu_o(sd_cpu), .desktop_o(desk), .ss_en_o(ss_en), .ss_wide_o(ss_wide),
    .ss_down_o(ss_down), .tristate_o(tri_st), .en_cpu_o(e_cpu), .en_pci_o(e_pci),
    .en_pci_free_o(e_pcif), .en_agp_o(e_agp), .en_sdram_o(e_sdr), .en_ref_o(e_ref)
  );

  function automatic logic [25:0] act_en();
    return {e_ref, e_sdr, e_agp, e_pcif, e_pci, e_cpu};
  endfunction

  function automatic logic [25:0] exp_en(logic d);
    logic [11:0] s;
    s = {b4[3] & d, b4[2] & d, b4[1:0], b3};
    return {b5[1:0], s, b5[4], b2[5], b2[6], b2[4:0], b1[3:0]};
  endfunction

  function automatic logic [7:0] scal();
    return {freq, sd_cpu, desk, ss_en, ss_wide, ss_down};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    fs_s = 3'b101; sd_s = 1'b0; md_s = 1'b1;
    b0 = 8'hFF; b1 = 8'h00; b2 = 8'h00; b3 = 8'h00; b4 = 8'h00; b5 = 8'h00;
    repeat (2) settle();
    chk("R2 scalars in reset", {24'h0, scal()}, {24'h0, 3'b000, 1'b1, 1'b1, 3'b000});
    chk("R2 tristate in reset", {31'h0, tri_st}, 32'h0);
    chk("R2 enables in reset", {6'h0, act_en()}, {6'h0, 26'h3FFFFFF});
    rst_ni = 1'b1;
    #1 chk("R2 enables before capture edge", {6'h0, act_en()}, {6'h0, 26'h3FFFFFF});
    @(negedge clk);
  endtask

  task automatic t_strap_hw();
    b0 = 8'h00; b1 = 8'hFF; b2 = 8'hFF; b3 = 8'hFF; b4 = 8'hFF; b5 = 8'hFF;
    settle();
    chk("R3 hw freq", {29'h0, freq}, 32'd5);
    chk("R5 sdram source", {31'h0, sd_cpu}, 32'd0);
    chk("R5 mode", {31'h0, desk}, 32'd1);
    fs_s = 3'b010; sd_s = 1'b1; md_s = 1'b0;
    repeat (3) settle();
    chk("R1 straps frozen", {24'h0, scal()}, {24'h0, 3'b101, 1'b0, 1'b1, 3'b000});
    chk("R1 enables unaffected", {6'h0, act_en()}, {6'h0, exp_en(1'b1)});
  endtask

  task automatic t_override();
    b0 = 8'b0011_1000;
    settle();
    chk("R4 sw freq 011", {29'h0, freq}, 32'd3);
    b0 = 8'b0111_1000;
    settle();
    chk("R4 sw freq 111", {29'h0, freq}, 32'd7);
    b0 = 8'b0111_0000;
    settle();
    chk("R3 back to strap", {29'h0, freq}, 32'd5);
  endtask

  task automatic t_spread();
    b0 = 8'b1000_0110;
    settle();
    chk("R6 wide down on", {29'h0, ss_en, ss_wide, ss_down}, 32'b111);
    chk("R7 tristate off", {31'h0, tri_st}, 32'd0);
    b0 = 8'b0000_0010;
    settle();
    chk("R6 narrow center on", {29'h0, ss_en, ss_wide, ss_down}, 32'b100);
    b0 = 8'b1000_0101;
    settle();
    chk("R6 spread disabled", {29'h0, ss_en, ss_wide, ss_down}, 32'b011);
    chk("R7 tristate on", {31'h0, tri_st}, 32'd1);
    b0 = 8'h00;
  endtask

  task automatic t_enables();
    b1 = 8'h05; b2 = 8'h2A; b3 = 8'hC3; b4 = 8'h06; b5 = 8'h12;
    settle();
    chk("R8 pattern A", {6'h0, act_en()}, {6'h0, exp_en(1'b1)});
    b1 = 8'h0A; b2 = 8'h55; b3 = 8'h3C; b4 = 8'h09; b5 = 8'h01;
    settle();
    chk("R8 pattern B", {6'h0, act_en()}, {6'h0, exp_en(1'b1)});
    b4 = 8'h0C;
    settle();
    chk("R9 desktop shared follow", {20'h0, e_sdr}, {20'h0, 4'hC, b3});
    b1 = 8'hF0; b2 = 8'h80; b3 = 8'h00; b4 = 8'hF0; b5 = 8'hEC;
    settle();
    chk("R10 reserved set, enables", {6'h0, act_en()}, {6'h0, 26'h0});
    chk("R10 reserved set, scalars", {24'h0, scal()}, {24'h0, 3'b101, 1'b0, 1'b1, 3'b000});
    chk("R10 reserved set, tristate", {31'h0, tri_st}, 32'd0);
  endtask

  task automatic t_mobile();
    b1 = 8'hFF; b2 = 8'hFF; b3 = 8'hFF; b4 = 8'hFF; b5 = 8'hFF; b0 = 8'h00;
    rst_ni = 1'b0;
    fs_s = 3'b010; sd_s = 1'b1; md_s = 1'b0;
    #1 chk("R11 reset restores defaults", {24'h0, scal()}, {24'h0, 3'b000, 1'b1, 1'b1, 3'b000});
    settle();
    rst_ni = 1'b1;
    settle();
    chk("R11 recapture", {24'h0, scal()}, {24'h0, 3'b010, 1'b1, 1'b0, 3'b000});
    chk("R9 mobile shared off", {20'h0, e_sdr}, {20'h0, 12'h3FF});
    chk("R8 mobile others", {6'h0, act_en()}, {6'h0, exp_en(1'b0)});
  endtask

  initial begin
    t_reset_state();
    t_strap_hw();
    t_override();
    t_spread();
    t_enables();
    t_mobile();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule